// File: doc/BRIEF.md
# Resistive Touch Scan Sequencer

This block runs the measurement cycle of a four-wire resistive touch panel without software help. While enabled it repeatedly walks a fixed chain of timed phases: a settle delay, the X conversion, a second settle delay, the Y conversion, then drain, pen-detect, touch-detect and update delays. Every timed phase lasts a programmable number of ticks of a slow sampling clock, which reaches the block as a one-cycle `tick_en` enable in the fast clock domain. For each axis it asks an external converter for a result with a start pulse and waits for the converter's done strobe. At the end of the touch-detect delay it packs both results with the pen state into one word and pushes that word into a four-entry FIFO.

Software reaches the block through a small register port with eight word addresses: status, control, the FIFO pop location and the five phase durations. The interrupt output asks for service once the FIFO has filled to four entries. A push into a full FIFO is dropped and leaves a sticky overrun flag, which software sees in the status word and which clears once the FIFO has been read out to empty.

The controller has nine named states. IDLE goes to SETTLE_X when both auto-enable and power-up are set. SETTLE_X goes to CONV_X, CONV_X to SETTLE_Y, SETTLE_Y to CONV_Y, CONV_Y to DRAIN, DRAIN to PEN_WAIT, PEN_WAIT to TOUCH_WAIT, TOUCH_WAIT to UPDATE, and UPDATE goes back to SETTLE_X. A timed state advances when its count expires. A conversion state advances on the converter's done strobe. At any of these boundaries the controller returns to IDLE if the run condition has been withdrawn.

Top module: `tscan_seq`

## Requirements
- R1: After reset the FIFO is empty, the status word reads 0x080, `irq`, `adc_start` and `adc_pwr` are low, and the settle, drain, touch-detect, pen-detect and update duration registers read 2, 2, 16, 4 and 88.
- R2: A timed phase programmed with N lasts max(N,1) ticks. From the edge that samples the X done strobe to the edge that raises the Y start there are max(settle,1) edges. From the Y done edge to the next X start there are max(drain,1)+max(pen,1)+max(touch,1)+max(update,1)+max(settle,1) edges while `tick_en` is held high.
- R3: Timed phases advance only in cycles with `tick_en` high. Conversion phases ignore `tick_en` and wait for `adc_done`.
- R4: `adc_start` is a one-cycle pulse raised on entry to each conversion phase. `adc_axis_y` is 0 during the X conversion and 1 during the Y conversion.
- R5: Each FIFO word carries X in bits 25:16, Y in bits 9:0 and in bit 31 the inverse of `pen_down` sampled at the end of touch-detect (1 means pen up). All other bits are zero.
- R6: Control bits 9:7 (X) and 6:4 (Y) hold 10 minus the wanted resolution. A value f clears the f low bits of that axis's result. The control word reads back as written in bits 0, 2, 4..9 and 11.
- R7: The FIFO holds four words in arrival order. A read of address 2 pops the oldest word, and the data appears on `reg_rdata` in the cycle after the read strobe.
- R8: A read of address 2 while the FIFO is empty returns the last popped word (0 after reset) and leaves the status unchanged.
- R9: A push into a full FIFO is discarded and sets status bit 8. That bit stays set until a pop leaves the FIFO empty.
- R10: `irq` is high exactly while control bit 11 is set and the FIFO holds four words.
- R11: The sequence starts from IDLE only when control bits 0 (auto-enable) and 2 (power-up) are both set. Clearing either one returns the block to IDLE at the next phase boundary, with no further start pulse or push.
- R12: Status bit 7 is high when the FIFO is empty, and status bits 2:0 give its fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable per slow sampling-clock tick |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 pops) |
| reg_addr | input | 3 | Word address: 0 status, 1 control, 2 FIFO, 3 settle, 4 drain, 5 touch-detect, 6 pen-detect, 7 update |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| adc_start | output | 1 | Conversion request pulse |
| adc_axis_y | output | 1 | Axis under conversion: 0 X, 1 Y |
| adc_pwr | output | 1 | Converter power-up level (control bit 2) |
| adc_done | input | 1 | Conversion complete strobe |
| adc_data | input | 10 | Conversion result, valid with `adc_done` |
| pen_down | input | 1 | Pen contact level from the panel detector |
| irq | output | 1 | FIFO-four-entries interrupt |

## Verification
The bench builds the block with its defaults: 8-bit durations, a four-entry FIFO and an interrupt level of four. A depth of four means five sample pairs fill the FIFO and force a discarded push, so the overrun set and clear paths are reached within a few hundred cycles. Holding `tick_en` high makes each tick one clock, so the bench can sweep every settle and drain value from 0 to 3 against every pen-detect, touch-detect and update value from 0 to 2. That sweep covers 432 combinations and checks both measured gaps against the max(N,1) sum. Sixteen sample pairs with arithmetic values and alternating pen state check the packing, ordering and interrupt level.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SETTLE_X,
        PH_CONV_X,
        PH_SETTLE_Y,
        PH_CONV_Y,
        PH_DRAIN,
        PH_PEN_WAIT,
        PH_TOUCH_WAIT,
        PH_UPDATE
    } phase_e;

    localparam int RES_W = 10;

    // register word addresses
    localparam logic [2:0] A_STATUS = 3'd0;
    localparam logic [2:0] A_CTRL   = 3'd1;
    localparam logic [2:0] A_FIFO   = 3'd2;
    localparam logic [2:0] A_SETTLE = 3'd3;
    localparam logic [2:0] A_DRAIN  = 3'd4;
    localparam logic [2:0] A_TOUCH  = 3'd5;
    localparam logic [2:0] A_PEN    = 3'd6;
    localparam logic [2:0] A_UPDATE = 3'd7;

    // control bit positions
    localparam int C_AUTO     = 0;
    localparam int C_PWR      = 2;
    localparam int C_YRES_LSB = 4;
    localparam int C_XRES_LSB = 7;
    localparam int C_IRQ4     = 11;

    // status bit positions
    localparam int S_EMPTY = 7;
    localparam int S_OVR   = 8;

    // duration defaults after reset
    localparam int DEF_SETTLE = 2;
    localparam int DEF_DRAIN  = 2;
    localparam int DEF_TOUCH  = 16;
    localparam int DEF_PEN    = 4;
    localparam int DEF_UPDATE = 88;

    function automatic logic [31:0] pack_sample(input logic pen_up,
                                                input logic [RES_W-1:0] xv,
                                                input logic [RES_W-1:0] yv);
        logic [31:0] w;
        w        = '0;
        w[31]    = pen_up;
        w[25:16] = xv;
        w[9:0]   = yv;
        return w;
    endfunction

    function automatic logic [RES_W-1:0] res_mask(input logic [2:0] drop);
        return {RES_W{1'b1}} << drop;
    endfunction

endpackage

// File: rtl/tscan_fifo.sv
module tscan_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [W-1:0]     last_q;
    logic             do_pop, do_push;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = empty ? last_q : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            last_q  <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
                last_q <= mem[rd_ptr];
            end
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
            if (push && full && !do_pop)
                overrun <= 1'b1;
            else if (do_pop && !do_push && count == CNT_W'(1))
                overrun <= 1'b0;
        end
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    a_r9_ovr_rise_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(full));

    a_r8_empty_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (empty && $stable(rdata)));

endmodule

// File: rtl/tscan_phase_fsm.sv
module tscan_phase_fsm
    import tscan_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick_en,
    input  logic [TICK_W-1:0] settle_t,
    input  logic [TICK_W-1:0] drain_t,
    input  logic [TICK_W-1:0] pen_t,
    input  logic [TICK_W-1:0] touch_t,
    input  logic [TICK_W-1:0] update_t,
    input  logic [2:0]        xres,
    input  logic [2:0]        yres,
    input  logic              adc_done,
    input  logic [RES_W-1:0]  adc_data,
    input  logic              pen_down,
    output logic              adc_start,
    output logic              adc_axis_y,
    output logic              push,
    output logic [31:0]       push_data
);

    phase_e            phase, nxt;
    logic [TICK_W-1:0] cnt, dur, dur_last;
    logic              is_timed, is_conv, timed_end;
    logic [RES_W-1:0]  x_q, y_q;

    always_comb begin
        unique case (phase)
            PH_SETTLE_X, PH_SETTLE_Y: dur = settle_t;
            PH_DRAIN:                 dur = drain_t;
            PH_PEN_WAIT:              dur = pen_t;
            PH_TOUCH_WAIT:            dur = touch_t;
            PH_UPDATE:                dur = update_t;
            default:                  dur = '0;
        endcase
    end

    assign is_timed  = (phase == PH_SETTLE_X) || (phase == PH_SETTLE_Y) ||
                       (phase == PH_DRAIN) || (phase == PH_PEN_WAIT) ||
                       (phase == PH_TOUCH_WAIT) || (phase == PH_UPDATE);
    assign is_conv   = (phase == PH_CONV_X) || (phase == PH_CONV_Y);
    assign dur_last  = (dur == '0) ? '0 : dur - TICK_W'(1);
    assign timed_end = is_timed && tick_en && (cnt >= dur_last);

    // next-state logic
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:       if (run)       nxt = PH_SETTLE_X;
            PH_SETTLE_X:   if (timed_end) nxt = run ? PH_CONV_X     : PH_IDLE;
            PH_CONV_X:     if (adc_done)  nxt = run ? PH_SETTLE_Y   : PH_IDLE;
            PH_SETTLE_Y:   if (timed_end) nxt = run ? PH_CONV_Y     : PH_IDLE;
            PH_CONV_Y:     if (adc_done)  nxt = run ? PH_DRAIN      : PH_IDLE;
            PH_DRAIN:      if (timed_end) nxt = run ? PH_PEN_WAIT   : PH_IDLE;
            PH_PEN_WAIT:   if (timed_end) nxt = run ? PH_TOUCH_WAIT : PH_IDLE;
            PH_TOUCH_WAIT: if (timed_end) nxt = run ? PH_UPDATE     : PH_IDLE;
            PH_UPDATE:     if (timed_end) nxt = run ? PH_SETTLE_X   : PH_IDLE;
            default:                      nxt = PH_IDLE;
        endcase
    end

    // state register and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= nxt;
            if (nxt != phase)          cnt <= '0;
            else if (is_timed && tick_en) cnt <= cnt + TICK_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_start <= 1'b0;
            x_q       <= '0;
            y_q       <= '0;
        end else begin
            adc_start <= ((nxt == PH_CONV_X) && (phase != PH_CONV_X)) ||
                         ((nxt == PH_CONV_Y) && (phase != PH_CONV_Y));
            if (phase == PH_CONV_X && adc_done) x_q <= adc_data & res_mask(xres);
            if (phase == PH_CONV_Y && adc_done) y_q <= adc_data & res_mask(yres);
        end
    end

    assign adc_axis_y = (phase == PH_CONV_Y);
    assign push       = (phase == PH_TOUCH_WAIT) && timed_end && run;
    assign push_data  = pack_sample(!pen_down, x_q, y_q);

    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    a_r4_start_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> is_conv);

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (is_timed && !tick_en) |=> $stable(phase));

    a_r3_conv_waits_done: assert property (@(posedge clk) disable iff (!rst_n)
        (is_conv && !adc_done) |=> $stable(phase));

    a_r2_x_then_y_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV_X && adc_done) |=> (phase == PH_SETTLE_Y || phase == PH_IDLE));

    a_r5_push_at_touch_end: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (phase == PH_UPDATE));

endmodule

// File: rtl/tscan_regs.sv
module tscan_regs
    import tscan_pkg::*;
#(
    parameter int TICK_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       fifo_rdata,
    input  logic              fifo_empty,
    input  logic              fifo_ovr,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_pop,
    output logic              run,
    output logic              pwr,
    output logic              irq4_en,
    output logic [2:0]        xres,
    output logic [2:0]        yres,
    output logic [TICK_W-1:0] settle_t,
    output logic [TICK_W-1:0] drain_t,
    output logic [TICK_W-1:0] touch_t,
    output logic [TICK_W-1:0] pen_t,
    output logic [TICK_W-1:0] update_t
);

    logic        auto_q;
    logic [31:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q   <= 1'b0;
            pwr      <= 1'b0;
            irq4_en  <= 1'b0;
            xres     <= '0;
            yres     <= '0;
            settle_t <= TICK_W'(DEF_SETTLE);
            drain_t  <= TICK_W'(DEF_DRAIN);
            touch_t  <= TICK_W'(DEF_TOUCH);
            pen_t    <= TICK_W'(DEF_PEN);
            update_t <= TICK_W'(DEF_UPDATE);
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    auto_q  <= reg_wdata[C_AUTO];
                    pwr     <= reg_wdata[C_PWR];
                    irq4_en <= reg_wdata[C_IRQ4];
                    xres    <= reg_wdata[C_XRES_LSB +: 3];
                    yres    <= reg_wdata[C_YRES_LSB +: 3];
                end
                A_SETTLE: settle_t <= reg_wdata[TICK_W-1:0];
                A_DRAIN:  drain_t  <= reg_wdata[TICK_W-1:0];
                A_TOUCH:  touch_t  <= reg_wdata[TICK_W-1:0];
                A_PEN:    pen_t    <= reg_wdata[TICK_W-1:0];
                A_UPDATE: update_t <= reg_wdata[TICK_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            A_STATUS: begin
                rd_mux[S_EMPTY]     = fifo_empty;
                rd_mux[S_OVR]       = fifo_ovr;
                rd_mux[CNT_W-1:0]   = fifo_count;
            end
            A_CTRL: begin
                rd_mux[C_AUTO]          = auto_q;
                rd_mux[C_PWR]           = pwr;
                rd_mux[C_IRQ4]          = irq4_en;
                rd_mux[C_XRES_LSB +: 3] = xres;
                rd_mux[C_YRES_LSB +: 3] = yres;
            end
            A_FIFO:   rd_mux = fifo_rdata;
            A_SETTLE: rd_mux[TICK_W-1:0] = settle_t;
            A_DRAIN:  rd_mux[TICK_W-1:0] = drain_t;
            A_TOUCH:  rd_mux[TICK_W-1:0] = touch_t;
            A_PEN:    rd_mux[TICK_W-1:0] = pen_t;
            A_UPDATE: rd_mux[TICK_W-1:0] = update_t;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assign run      = auto_q && pwr;
    assign fifo_pop = reg_rd && (reg_addr == A_FIFO);

    a_r12_status_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STATUS && fifo_empty) |=> (reg_rdata[CNT_W-1:0] == '0));

endmodule

// File: rtl/tscan_seq.sv
module tscan_seq
    import tscan_pkg::*;
#(
    parameter int TICK_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int IRQ_LEVEL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             adc_start,
    output logic             adc_axis_y,
    output logic             adc_pwr,
    input  logic             adc_done,
    input  logic [RES_W-1:0] adc_data,
    input  logic             pen_down,
    output logic             irq
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic              run, irq4_en;
    logic [2:0]        xres, yres;
    logic [TICK_W-1:0] settle_t, drain_t, touch_t, pen_t, update_t;
    logic              push, pop, f_empty, f_full, f_ovr;
    logic [31:0]       push_data, f_rdata;
    logic [CNT_W-1:0]  f_count;

    tscan_regs #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fifo_rdata (f_rdata),
        .fifo_empty (f_empty),
        .fifo_ovr   (f_ovr),
        .fifo_count (f_count),
        .fifo_pop   (pop),
        .run        (run),
        .pwr        (adc_pwr),
        .irq4_en    (irq4_en),
        .xres       (xres),
        .yres       (yres),
        .settle_t   (settle_t),
        .drain_t    (drain_t),
        .touch_t    (touch_t),
        .pen_t      (pen_t),
        .update_t   (update_t)
    );

    tscan_phase_fsm #(.TICK_W(TICK_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick_en    (tick_en),
        .settle_t   (settle_t),
        .drain_t    (drain_t),
        .pen_t      (pen_t),
        .touch_t    (touch_t),
        .update_t   (update_t),
        .xres       (xres),
        .yres       (yres),
        .adc_done   (adc_done),
        .adc_data   (adc_data),
        .pen_down   (pen_down),
        .adc_start  (adc_start),
        .adc_axis_y (adc_axis_y),
        .push       (push),
        .push_data  (push_data)
    );

    tscan_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wdata   (push_data),
        .pop     (pop),
        .rdata   (f_rdata),
        .empty   (f_empty),
        .full    (f_full),
        .count   (f_count),
        .overrun (f_ovr)
    );

    assign irq = irq4_en && (f_count >= CNT_W'(IRQ_LEVEL));

    a_r10_irq_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (f_full || IRQ_LEVEL < FIFO_DEPTH));

    a_r11_no_start_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_pwr && $past(!adc_pwr)) |-> !adc_start);

endmodule

// File: tb/tscan_seq_test.sv
module tscan_seq_test;
    import tscan_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        adc_start, adc_axis_y, adc_pwr, irq;
    logic        adc_done = 1'b0;
    logic [9:0]  adc_data = '0;
    logic        pen_down = 1'b0;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tscan_seq uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adc_start(adc_start), .adc_axis_y(adc_axis_y), .adc_pwr(adc_pwr),
        .adc_done(adc_done), .adc_data(adc_data), .pen_down(pen_down),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_start(output int n);
        n = 0;
        while (!adc_start && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // called at a negedge where a conversion is pending
    task automatic give_done(input logic [9:0] v, output int n);
        adc_data = v; adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        n = 0;
        while (!adc_start && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [31:0] word(input logic pd, input logic [9:0] xv, input logic [9:0] yv);
        return {!pd, 5'b0, xv, 6'b0, yv};
    endfunction

    // one sample pair, entered and left at an X start
    task automatic pair(input logic [9:0] xv, input logic [9:0] yv, input logic pd);
        int n;
        give_done(xv, n);
        check("R4 axis select during Y conversion", {31'b0, adc_axis_y}, 32'd1);
        pen_down = pd;
        give_done(yv, n);
        check("R4 axis select during X conversion", {31'b0, adc_axis_y}, 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] expw [4];
        int n, starts;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 0);
        check("R1 adc_start after reset", {31'b0, adc_start}, 0);
        check("R1 adc_pwr after reset", {31'b0, adc_pwr}, 0);
        rd(A_STATUS, d); check("R1 R12 status after reset", d, 32'h080);
        rd(A_SETTLE, d); check("R1 settle default", d, 2);
        rd(A_DRAIN, d);  check("R1 drain default", d, 2);
        rd(A_TOUCH, d);  check("R1 touch default", d, 16);
        rd(A_PEN, d);    check("R1 pen default", d, 4);
        rd(A_UPDATE, d); check("R1 update default", d, 88);
        rd(A_FIFO, d);   check("R8 empty read after reset", d, 0);
        rd(A_STATUS, d); check("R8 status unchanged by empty read", d, 32'h080);

        // R11 auto without power: no start
        wr(A_CTRL, 32'h001);
        starts = 0;
        repeat (30) begin @(negedge clk); if (adc_start) starts++; end
        check("R11 no start without power", starts, 0);

        wr(A_SETTLE, 1); wr(A_DRAIN, 1); wr(A_TOUCH, 1); wr(A_PEN, 1); wr(A_UPDATE, 1);
        wr(A_CTRL, 32'h805);
        check("R11 power output", {31'b0, adc_pwr}, 1);
        wait_start(n);
        check("R11 start with both bits", {31'b0, adc_start}, 1);
        check("R4 first conversion is X", {31'b0, adc_axis_y}, 0);

        // R5 R7 R10 R12 data chunks
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 4; i++) begin
                int k;
                logic [9:0] xv, yv;
                logic pd;
                k  = c * 4 + i;
                xv = 10'((k * 73 + 5) & 32'h3FF);
                yv = 10'((k * 151 + 1000) & 32'h3FF);
                pd = k[0];
                expw[i] = word(pd, xv, yv);
                pair(xv, yv, pd);
                if (i == 2) check("R10 irq low at three entries", {31'b0, irq}, 0);
            end
            check("R10 irq high at four entries", {31'b0, irq}, 1);
            rd(A_STATUS, d); check("R12 status full level", d, 32'h004);
            for (int i = 0; i < 4; i++) begin
                rd(A_FIFO, d); check("R5 R7 packed word in order", d, expw[i]);
            end
            check("R10 irq low after drain", {31'b0, irq}, 0);
            rd(A_STATUS, d); check("R12 status empty after drain", d, 32'h080);
            rd(A_FIFO, d); check("R8 empty read returns last", d, expw[3]);
            rd(A_STATUS, d); check("R8 status unchanged", d, 32'h080);
        end

        // R6 resolution
        wr(A_CTRL, 32'h955);
        rd(A_CTRL, d); check("R6 control readback", d, 32'h955);
        pair(10'h3FF, 10'h2AB, 1'b1);
        rd(A_FIFO, d); check("R6 resolution masking", d, word(1'b1, 10'h3FC, 10'h2A0));
        wr(A_CTRL, 32'h805);

        // R9 overrun
        for (int i = 0; i < 5; i++) begin
            logic [9:0] xv, yv;
            xv = 10'(i * 200 + 3);
            yv = 10'(1023 - i * 100);
            if (i < 4) expw[i] = word(1'b1, xv, yv);
            pair(xv, yv, 1'b1);
        end
        rd(A_STATUS, d); check("R9 overrun set when full", d, 32'h104);
        check("R10 irq during overrun", {31'b0, irq}, 1);
        for (int i = 0; i < 3; i++) begin
            rd(A_FIFO, d); check("R9 fifth sample discarded", d, expw[i]);
        end
        rd(A_STATUS, d); check("R9 overrun sticky until empty", d, 32'h101);
        rd(A_FIFO, d); check("R9 last kept sample", d, expw[3]);
        rd(A_STATUS, d); check("R9 overrun cleared at empty", d, 32'h080);
        rd(A_FIFO, d); check("R8 empty read after overrun", d, expw[3]);

        // R3 tick gating, settle 3
        wr(A_SETTLE, 3);
        tick_en = 1'b0;
        adc_data = 10'h011; adc_done = 1'b1;
        @(negedge clk); adc_done = 1'b0;
        starts = 0;
        repeat (20) begin @(negedge clk); if (adc_start) starts++; end
        check("R3 settle holds without tick", starts, 0);
        tick_en = 1'b1;
        n = 0;
        while (!adc_start && n < 5000) begin @(negedge clk); n++; end
        check("R3 settle resumes with tick", n, 3);
        give_done(10'h022, n);
        check("R2 Y to X gap", n, 1 + 1 + 1 + 1 + 3);
        rd(A_FIFO, d); check("R3 sample after gated phase", d, word(1'b1, 10'h011, 10'h022));

        // R11 stop at boundary
        wr(A_CTRL, 32'h804);
        adc_data = 10'h055; adc_done = 1'b1;
        @(negedge clk); adc_done = 1'b0;
        starts = 0;
        repeat (40) begin @(negedge clk); if (adc_start) starts++; end
        check("R11 no start after auto cleared", starts, 0);
        rd(A_STATUS, d); check("R11 no push after stop", d, 32'h080);
        wr(A_CTRL, 32'h805);
        wait_start(n);
        check("R11 restart after re-enable", {31'b0, adc_start}, 1);
        check("R11 restart begins with X", {31'b0, adc_axis_y}, 0);

        // R2 duration sweep
        for (int s = 0; s < 4; s++)
            for (int dr = 0; dr < 4; dr++)
                for (int p = 0; p < 3; p++)
                    for (int t = 0; t < 3; t++)
                        for (int u = 0; u < 3; u++) begin
                            wr(A_SETTLE, s); wr(A_DRAIN, dr); wr(A_PEN, p);
                            wr(A_TOUCH, t); wr(A_UPDATE, u);
                            give_done(10'h100, n);
                            check("R2 X to Y gap", n, eff(s));
                            give_done(10'h200, n);
                            check("R2 Y to X gap", n, eff(dr) + eff(p) + eff(t) + eff(u) + eff(s));
                        end

        finish_run();
    end
endmodule